// File: doc/BRIEF.md
# Audio Sample FIFO Refill Trigger and DMA Channel Sequencer

This block links a set of free-running timers to two audio sample FIFOs and to the DMA channels that keep those FIFOs topped up. Each FIFO is tied to one timer chosen by a select field. Each overflow of that timer pops one sample from the FIFO. If the count left after the pop is low enough, and the FIFO's paired channel is enabled in special-timing mode, the channel is armed for a refill burst.

Each channel runs a small state machine with three states: `CH_IDLE` (not active), `CH_WAIT` (active, startup delay counting down) and `CH_RUN` (active, requesting words). There are three transitions. *Arm* goes from `CH_IDLE` to `CH_WAIT` on a trigger. *Expire* goes from `CH_WAIT` to `CH_RUN` when the delay count runs out. *Finish* goes from `CH_RUN` to `CH_IDLE` on the acknowledge of the last word of the burst. A fixed-priority arbiter picks one running channel and presents it on a request/acknowledge handshake. Any channel can also be armed directly by a kick input, which stands for trigger sources outside this block. Address generation, bus arbitration and data movement are out of scope.

Top module: `snd_refill_dma_ctrl`

## Requirements
- R1: `fifo_pop[n]` is high in exactly those cycles where `timer_ovf[k]` is high, with k being the 2-bit value in `fifo_tsel[2n+1:2n]`.
- R2: A pop asks for a refill only if the remaining count is 16 or less. The remaining count is `fifo_level` minus one, or zero when `fifo_level` is already zero. So a level of 17 or 0 arms a refill and a level of 18 does not.
- R3: FIFO 0 arms channel 1 and FIFO 1 arms channel 2. Arming happens only when that channel's `ch_enable` bit is set and its 2-bit timing field `ch_timing[2c+1:2c]` equals 3. `xfer_refill` is high while a burst armed this way is being requested.
- R4: A channel triggered in cycle t shows `ch_active` from cycle t+1. It does not request in cycles t+1 and t+2, which is the two-cycle startup wait. It may request from cycle t+3 on.
- R5: While `cpu_stopped` is high, `xfer_req` stays low. The startup wait still counts down during this time, so a channel whose wait has run out requests in the first cycle after `cpu_stopped` falls.
- R6: When several channels are ready, `xfer_ch` names the lowest-numbered one.
- R7: Every burst is four words long. `ch_active` clears in the cycle after the acknowledge of the fourth word.
- R8: A trigger that reaches a channel which is already active has no effect: the burst in flight still ends after four acknowledges in total.
- R9: `dma_irq[c]` pulses in the same cycle as the acknowledge of the last word of channel c, but only if `ch_irq_en[c]` is set.
- R10: `cart_irq` pulses with the last-word acknowledge of channel 3 when `ch3_drq_en` is set, whatever `ch_irq_en[3]` holds.
- R11: `ch_kick[c]` arms an idle channel c with the same wait and burst length, and `xfer_refill` stays low for that burst.
- R12: During reset all channels are idle and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_ovf | input | 4 | One overflow strobe per timer |
| fifo_tsel | input | 4 | Timer select, 2 bits per FIFO |
| fifo_level | input | 12 | Current sample count, 6 bits per FIFO |
| ch_enable | input | 4 | Channel enable bits |
| ch_timing | input | 8 | Timing mode, 2 bits per channel |
| ch_irq_en | input | 4 | Completion interrupt enable per channel |
| ch3_drq_en | input | 1 | Cartridge interrupt enable for channel 3 |
| ch_kick | input | 4 | Direct arm request per channel |
| cpu_stopped | input | 1 | Blocks all transfer requests |
| xfer_ack | input | 1 | Acknowledge of the current word |
| fifo_pop | output | 2 | Pop strobe per FIFO |
| ch_active | output | 4 | Channel active flags |
| xfer_req | output | 1 | Transfer request |
| xfer_ch | output | 2 | Channel being requested |
| xfer_refill | output | 1 | Requested burst is a FIFO refill |
| dma_irq | output | 4 | Completion interrupt pulses |
| cart_irq | output | 1 | Cartridge interrupt pulse |

## Verification
The assertions check the following on every cycle: no request while the CPU is stopped, a request always comes from an active channel, the lowest ready channel wins, a channel makes no request in its first two active cycles, a channel stays active until it gets an acknowledge, and interrupts fire only on an acknowledged request of the right channel. Other behaviour can only be shown by the bench scenarios, where the behavioural model counts the sequence out: the level threshold at 16, 17, 18 and 0, the timing-mode filter, the exact four-word burst length, ignored retriggers, and the first request coming right after a stop is released.

// File: rtl/snd_refill_pkg.sv
package snd_refill_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2
    } chan_state_e;

    localparam logic [1:0] SPECIAL_TIMING = 2'd3;
endpackage

// File: rtl/snd_fifo_tap.sv
module snd_fifo_tap #(
    parameter int NUM_TIMERS = 4,
    parameter int LVL_W      = 6,
    parameter int THRESH     = 16,
    localparam int TSEL_W    = $clog2(NUM_TIMERS)
) (
    input  logic [NUM_TIMERS-1:0] timer_ovf,
    input  logic [TSEL_W-1:0]     tsel,
    input  logic [LVL_W-1:0]      level,
    input  logic                  ch_en,
    input  logic [1:0]            ch_timing,
    output logic                  pop,
    output logic                  refill
);
    import snd_refill_pkg::*;

    logic [LVL_W-1:0] remaining;

    always_comb begin
        pop       = timer_ovf[tsel];
        remaining = (level == '0) ? '0 : level - 1'b1;
        refill    = pop && (remaining <= LVL_W'(THRESH))
                    && ch_en && (ch_timing == SPECIAL_TIMING);
    end
endmodule

// File: rtl/snd_dma_chan.sv
module snd_dma_chan #(
    parameter int START_WAIT  = 2,
    parameter int BURST_WORDS = 4,
    localparam int WAIT_W     = $clog2(START_WAIT + 1),
    localparam int WORD_W     = $clog2(BURST_WORDS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_refill,
    input  logic ack_me,
    output logic active,
    output logic ready,
    output logic last,
    output logic refill
);
    import snd_refill_pkg::*;

    chan_state_e       state_q, state_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic [WORD_W-1:0] words_q, words_d;
    logic              refill_q, refill_d;

    // next-state logic: arm, expire, finish
    always_comb begin
        state_d  = state_q;
        wait_d   = wait_q;
        words_d  = words_q;
        refill_d = refill_q;
        unique case (state_q)
            CH_IDLE: begin
                if (start) begin
                    state_d  = CH_WAIT;
                    wait_d   = WAIT_W'(START_WAIT);
                    words_d  = WORD_W'(BURST_WORDS);
                    refill_d = start_refill;
                end
            end
            CH_WAIT: begin
                wait_d = wait_q - 1'b1;
                if (wait_q <= WAIT_W'(1)) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (ack_me) begin
                    words_d = words_q - 1'b1;
                    if (words_q == WORD_W'(1)) begin
                        state_d  = CH_IDLE;
                        refill_d = 1'b0;
                    end
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CH_IDLE;
            wait_q   <= '0;
            words_q  <= '0;
            refill_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            wait_q   <= wait_d;
            words_q  <= words_d;
            refill_q <= refill_d;
        end
    end

    always_comb begin
        active = (state_q != CH_IDLE);
        ready  = (state_q == CH_RUN);
        last   = (state_q == CH_RUN) && (words_q == WORD_W'(1));
        refill = refill_q;
    end
endmodule

// File: rtl/snd_dma_arb.sv
module snd_dma_arb #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] ready,
    input  logic              stopped,
    output logic              req,
    output logic [CH_W-1:0]   grant_idx,
    output logic [NUM_CH-1:0] grant_oh
);
    logic [NUM_CH-1:0] eligible;

    always_comb begin
        eligible  = stopped ? '0 : ready;
        grant_oh  = '0;
        grant_idx = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (eligible[c]) begin
                grant_oh    = '0;
                grant_oh[c] = 1'b1;
                grant_idx   = CH_W'(c);
            end
        end
        req = |eligible;
    end
endmodule

// File: rtl/snd_refill_dma_ctrl.sv
module snd_refill_dma_ctrl #(
    parameter int NUM_TIMERS  = 4,
    parameter int NUM_CH      = 4,
    parameter int NUM_FIFO    = 2,
    parameter int LVL_W       = 6,
    parameter int THRESH      = 16,
    parameter int START_WAIT  = 2,
    parameter int BURST_WORDS = 4,
    localparam int TSEL_W     = $clog2(NUM_TIMERS),
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TIMERS-1:0]      timer_ovf,
    input  logic [NUM_FIFO*TSEL_W-1:0] fifo_tsel,
    input  logic [NUM_FIFO*LVL_W-1:0]  fifo_level,
    input  logic [NUM_CH-1:0]          ch_enable,
    input  logic [NUM_CH*2-1:0]        ch_timing,
    input  logic [NUM_CH-1:0]          ch_irq_en,
    input  logic                       ch3_drq_en,
    input  logic [NUM_CH-1:0]          ch_kick,
    input  logic                       cpu_stopped,
    input  logic                       xfer_ack,
    output logic [NUM_FIFO-1:0]        fifo_pop,
    output logic [NUM_CH-1:0]          ch_active,
    output logic                       xfer_req,
    output logic [CH_W-1:0]            xfer_ch,
    output logic                       xfer_refill,
    output logic [NUM_CH-1:0]          dma_irq,
    output logic                       cart_irq
);
    logic [NUM_FIFO-1:0] fifo_refill;
    logic [NUM_CH-1:0]   chan_start, chan_from_fifo, chan_ready;
    logic [NUM_CH-1:0]   chan_last, chan_refill, grant_oh, ack_vec;

    // FIFO n is serviced by channel n+1
    for (genvar n = 0; n < NUM_FIFO; n++) begin : g_fifo
        snd_fifo_tap #(
            .NUM_TIMERS(NUM_TIMERS), .LVL_W(LVL_W), .THRESH(THRESH)
        ) tap_i (
            .timer_ovf (timer_ovf),
            .tsel      (fifo_tsel[n*TSEL_W +: TSEL_W]),
            .level     (fifo_level[n*LVL_W +: LVL_W]),
            .ch_en     (ch_enable[n+1]),
            .ch_timing (ch_timing[(n+1)*2 +: 2]),
            .pop       (fifo_pop[n]),
            .refill    (fifo_refill[n])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        if (c >= 1 && c <= NUM_FIFO) begin : g_fed
            assign chan_from_fifo[c] = fifo_refill[c-1];
        end else begin : g_unfed
            assign chan_from_fifo[c] = 1'b0;
        end
        assign chan_start[c] = chan_from_fifo[c] | ch_kick[c];
        assign ack_vec[c]    = xfer_ack & grant_oh[c];

        snd_dma_chan #(
            .START_WAIT(START_WAIT), .BURST_WORDS(BURST_WORDS)
        ) chan_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .start        (chan_start[c]),
            .start_refill (chan_from_fifo[c]),
            .ack_me       (ack_vec[c]),
            .active       (ch_active[c]),
            .ready        (chan_ready[c]),
            .last         (chan_last[c]),
            .refill       (chan_refill[c])
        );
    end

    snd_dma_arb #(.NUM_CH(NUM_CH)) arb_i (
        .ready     (chan_ready),
        .stopped   (cpu_stopped),
        .req       (xfer_req),
        .grant_idx (xfer_ch),
        .grant_oh  (grant_oh)
    );

    logic [NUM_CH-1:0] done_vec;

    always_comb begin
        done_vec    = ack_vec & chan_last;
        dma_irq     = done_vec & ch_irq_en;
        cart_irq    = done_vec[NUM_CH-1] & ch3_drq_en;
        xfer_refill = |(grant_oh & chan_refill);
    end
endmodule

// File: rtl/snd_refill_dma_chk.sv
module snd_refill_dma_chk #(
    parameter int NUM_TIMERS = 4,
    parameter int NUM_CH     = 4,
    localparam int TSEL_W    = $clog2(NUM_TIMERS),
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_TIMERS-1:0] timer_ovf,
    input logic [2*TSEL_W-1:0]   fifo_tsel,
    input logic [1:0]            fifo_pop,
    input logic                  cpu_stopped,
    input logic                  xfer_req,
    input logic [CH_W-1:0]       xfer_ch,
    input logic                  xfer_ack,
    input logic [NUM_CH-1:0]     ch_active,
    input logic [NUM_CH-1:0]     chan_ready,
    input logic [NUM_CH-1:0]     dma_irq,
    input logic                  cart_irq
);
    logic [NUM_CH-1:0] below_mask;
    always_comb below_mask = (NUM_CH'(1) << xfer_ch) - NUM_CH'(1);

    for (genvar n = 0; n < 2; n++) begin : g_f
        AST_POP_FOLLOWS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_pop[n] == timer_ovf[fifo_tsel[n*TSEL_W +: TSEL_W]]); // R1
    end

    AST_STOP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stopped |-> !xfer_req); // R5

    AST_REQ_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> ch_active[xfer_ch]); // R4

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> ((chan_ready & below_mask) == '0)); // R6

    AST_CART_ON_CH3: assert property (@(posedge clk) disable iff (!rst_n)
        cart_irq |-> (xfer_req && xfer_ack && xfer_ch == CH_W'(NUM_CH-1))); // R10

    for (genvar k = 0; k < NUM_CH; k++) begin : g_c
        AST_WAIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_active[k]) |-> !(xfer_req && xfer_ch == CH_W'(k))); // R4
        AST_WAIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_active[k]) |=> !(xfer_req && xfer_ch == CH_W'(k))); // R4
        AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_active[k] && !(xfer_req && xfer_ack && xfer_ch == CH_W'(k)))
            |=> ch_active[k]); // R8
        AST_IRQ_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            dma_irq[k] |-> (xfer_req && xfer_ack && xfer_ch == CH_W'(k))); // R9
        AST_IRQ_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
            dma_irq[k] |=> !ch_active[k]); // R7
    end
endmodule

bind snd_refill_dma_ctrl snd_refill_dma_chk #(
    .NUM_TIMERS(NUM_TIMERS), .NUM_CH(NUM_CH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .timer_ovf   (timer_ovf),
    .fifo_tsel   (fifo_tsel),
    .fifo_pop    (fifo_pop),
    .cpu_stopped (cpu_stopped),
    .xfer_req    (xfer_req),
    .xfer_ch     (xfer_ch),
    .xfer_ack    (xfer_ack),
    .ch_active   (ch_active),
    .chan_ready  (chan_ready),
    .dma_irq     (dma_irq),
    .cart_irq    (cart_irq)
);

// File: tb/snd_refill_dma_ctrl_tb.sv
module snd_refill_dma_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  timer_ovf = '0;
    logic [3:0]  fifo_tsel = '0;
    logic [11:0] fifo_level = '0;
    logic [3:0]  ch_enable = '0;
    logic [7:0]  ch_timing = '0;
    logic [3:0]  ch_irq_en = '0;
    logic        ch3_drq_en = 1'b0;
    logic [3:0]  ch_kick = '0;
    logic        cpu_stopped = 1'b0;
    logic        xfer_ack = 1'b0;
    logic [1:0]  fifo_pop;
    logic [3:0]  ch_active;
    logic        xfer_req;
    logic [1:0]  xfer_ch;
    logic        xfer_refill;
    logic [3:0]  dma_irq;
    logic        cart_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    snd_refill_dma_ctrl dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FIL%s %s: actual=%0d expected=%0d", "", req, act, exp);
        end
    endtask

    // reference model: integers per channel, updated once per cycle
    int  m_wait [4];
    int  m_words[4];
    bit  m_act  [4];
    bit  m_ref  [4];

    always @(negedge clk) begin : model
        bit [1:0] e_pop;
        bit [1:0] e_trig;
        bit [3:0] e_irq;
        bit       e_req, e_cart, e_refill;
        int       e_ch, rem;
        bit [3:0] e_act;
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_wait[c] = 0; m_words[c] = 0; m_act[c] = 0; m_ref[c] = 0;
            end
            chk({fifo_pop, ch_active, xfer_req, dma_irq, cart_irq} == '0, "R12",
                int'({fifo_pop, ch_active, xfer_req, dma_irq, cart_irq}), 0);
        end else begin
            for (int n = 0; n < 2; n++) begin
                e_pop[n]  = timer_ovf[fifo_tsel[n*2 +: 2]];
                rem       = (fifo_level[n*6 +: 6] == 0) ? 0 : int'(fifo_level[n*6 +: 6]) - 1;
                e_trig[n] = e_pop[n] && rem <= 16 && ch_enable[n+1]
                            && ch_timing[(n+1)*2 +: 2] == 2'd3;
            end
            e_req = 0; e_ch = 0;
            for (int c = 3; c >= 0; c--)
                if (m_act[c] && m_wait[c] == 0 && !cpu_stopped) begin
                    e_req = 1; e_ch = c;
                end
            e_irq = '0; e_cart = 0;
            e_refill = e_req && m_ref[e_ch];
            if (e_req && xfer_ack && m_words[e_ch] == 1) begin
                e_irq[e_ch] = ch_irq_en[e_ch];
                e_cart = (e_ch == 3) && ch3_drq_en;
            end
            for (int c = 0; c < 4; c++) e_act[c] = m_act[c];
            chk(fifo_pop == e_pop, "R1", fifo_pop, e_pop);
            chk(ch_active == e_act, "R4", ch_active, e_act);
            chk(xfer_req == e_req, "R5", xfer_req, e_req);
            if (e_req) begin
                chk(xfer_ch == 2'(e_ch), "R6", xfer_ch, e_ch);
                chk(xfer_refill == e_refill, "R3", xfer_refill, e_refill);
            end
            chk(dma_irq == e_irq, "R9", dma_irq, e_irq);
            chk(cart_irq == e_cart, "R10", cart_irq, e_cart);
            // advance the model to the next cycle
            for (int c = 0; c < 4; c++) begin
                bit fifo_st;
                fifo_st = (c == 1) ? e_trig[0] : (c == 2) ? e_trig[1] : 1'b0;
                if (!m_act[c]) begin
                    if (fifo_st || ch_kick[c]) begin
                        m_act[c] = 1; m_wait[c] = 2; m_words[c] = 4; m_ref[c] = fifo_st;
                    end
                end else if (m_wait[c] > 0) begin
                    m_wait[c]--;
                end else if (e_req && e_ch == c && xfer_ack) begin
                    m_words[c]--;
                    if (m_words[c] == 0) begin
                        m_act[c] = 0; m_ref[c] = 0;
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        xfer_ack = 1'b1;
        tick(20);
        xfer_ack = 1'b0;
        tick(1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        @(negedge clk);
        chk(ch_active == 0 && !xfer_req, "R12", ch_active, 0);
        tick(1);
        rst_n = 1'b1;
        tick(2);

        // R1 R3 R4 R7 R9: FIFO0 on timer 2, refill through channel 1
        fifo_tsel = 4'b0010; fifo_level[5:0] = 6'd10;
        ch_enable = 4'b0110; ch_timing = 8'b0011_1100; ch_irq_en = 4'b0010;
        timer_ovf = 4'b0100;
        @(negedge clk);
        chk(fifo_pop == 2'b01, "R1", fifo_pop, 1);
        tick(1); timer_ovf = '0;
        @(negedge clk);
        chk(ch_active[1] && !xfer_req, "R4", xfer_req, 0);
        tick(1);
        @(negedge clk);
        chk(!xfer_req, "R4", xfer_req, 0);
        tick(1); xfer_ack = 1'b1;
        @(negedge clk);
        chk(xfer_req && xfer_ch == 2'd1, "R4", xfer_ch, 1);
        chk(xfer_refill, "R3", xfer_refill, 1);
        tick(3);
        @(negedge clk);
        chk(dma_irq == 4'b0010, "R9", dma_irq, 2);
        tick(1); xfer_ack = 1'b0;
        @(negedge clk);
        chk(!ch_active[1], "R7", ch_active[1], 0);

        // R2: threshold edges
        fifo_level[5:0] = 6'd18; timer_ovf = 4'b0100;
        tick(1); timer_ovf = '0;
        @(negedge clk);
        chk(!ch_active[1], "R2", ch_active[1], 0);
        tick(1); fifo_level[5:0] = 6'd17; timer_ovf = 4'b0100;
        tick(1); timer_ovf = '0;
        @(negedge clk);
        chk(ch_active[1], "R2", ch_active[1], 1);
        drain();
        fifo_level[5:0] = 6'd0; timer_ovf = 4'b0100;
        tick(1); timer_ovf = '0;
        @(negedge clk);
        chk(ch_active[1], "R2", ch_active[1], 1);
        drain();

        // R3: timing mode other than 3 does not arm
        ch_timing[3:2] = 2'd2; fifo_level[5:0] = 6'd5; timer_ovf = 4'b0100;
        tick(1); timer_ovf = '0;
        @(negedge clk);
        chk(!ch_active[1], "R3", ch_active[1], 0);
        ch_timing[3:2] = 2'd3;

        // R5: stop holds the request, wait still expires
        tick(1);
        cpu_stopped = 1'b1; fifo_tsel = 4'b0000; fifo_level[11:6] = 6'd3;
        timer_ovf = 4'b0001; fifo_level[5:0] = 6'd40;
        tick(1); timer_ovf = '0;
        tick(4);
        @(negedge clk);
        chk(ch_active[2] && !xfer_req, "R5", xfer_req, 0);
        tick(1); cpu_stopped = 1'b0;
        @(negedge clk);
        chk(xfer_req && xfer_ch == 2'd2, "R5", xfer_ch, 2);
        drain();

        // R6: both FIFOs on timer 0 in the same cycle
        fifo_level = {6'd4, 6'd4}; timer_ovf = 4'b0001;
        tick(1); timer_ovf = '0;
        tick(2); xfer_ack = 1'b1;
        @(negedge clk);
        chk(xfer_ch == 2'd1, "R6", xfer_ch, 1);
        tick(4);
        @(negedge clk);
        chk(xfer_req && xfer_ch == 2'd2, "R6", xfer_ch, 2);
        tick(4); xfer_ack = 1'b0;
        @(negedge clk);
        chk(ch_active == 0, "R7", ch_active, 0);

        // R8: retrigger while active is ignored
        fifo_level = {6'd40, 6'd4}; timer_ovf = 4'b0001;
        tick(1); timer_ovf = '0;
        tick(2); xfer_ack = 1'b1;
        tick(1); timer_ovf = 4'b0001;
        tick(1); timer_ovf = '0;
        tick(2);
        @(negedge clk);
        chk(!ch_active[1], "R8", ch_active[1], 0);
        xfer_ack = 1'b0;
        tick(2);

        // R10 R11: kick channel 3 with cartridge interrupt only
        ch3_drq_en = 1'b1; ch_irq_en = 4'b0000; ch_kick = 4'b1000;
        tick(1); ch_kick = '0;
        tick(2); xfer_ack = 1'b1;
        @(negedge clk);
        chk(xfer_req && xfer_ch == 2'd3 && !xfer_refill, "R11", xfer_refill, 0);
        tick(3);
        @(negedge clk);
        chk(cart_irq && dma_irq == 0, "R10", cart_irq, 1);
        tick(1); xfer_ack = 1'b0;
        tick(2);

        // mixed soak, compared against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            timer_ovf   = ($urandom % 6 == 0) ? 4'($urandom) : 4'b0;
            fifo_tsel   = 4'($urandom);
            fifo_level  = {6'($urandom % 24), 6'($urandom % 24)};
            ch_enable   = 4'($urandom) | 4'b0110;
            ch_timing   = ($urandom % 4 == 0) ? 8'($urandom) : 8'b1111_1111;
            ch_irq_en   = 4'($urandom);
            ch3_drq_en  = 1'($urandom);
            ch_kick     = ($urandom % 30 == 0) ? 4'(1 << ($urandom % 4)) : 4'b0;
            cpu_stopped = ($urandom % 8 == 0);
            xfer_ack    = ($urandom % 3 != 0);
            tick(1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule